// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Stage

A small up-counter slice (four bits by default) whose state bits all change on the rising clock edge. An active-low input forces the count to zero at once, without waiting for a clock. An active-low load input copies a parallel data word into the count on the next rising edge. Two active-high enables gate counting, and the count advances only when both are high. A falling clock edge never changes the state.

The terminal output is combinational. It is high when the count is all ones and the chain enable is high. The plain count enable has no effect on it. A wider counter is built by feeding each stage's terminal output into the chain enable of the stage above. The zero input, load, count enable and clock are shared by all stages, so the whole chain advances in a single edge with no ripple.

Top module: `sync_count_stage`

## Requirements
- R1: While `zero_n` is low, `q` is 0 at once, without a clock edge, whatever `ld_n`, the enables and `din` are.
- R2: On a rising edge with `zero_n` high and `ld_n` low, `q` takes `din`, with `din[0]` going to `q[0]`. This happens whatever the enables are, so load wins over counting.
- R3: On a rising edge with `zero_n` and `ld_n` high and both `cnt_en` and `chain_en` high, `q` increases by one.
- R4: With `zero_n` and `ld_n` high and `cnt_en` low, `q` holds across rising edges.
- R5: With `zero_n` and `ld_n` high and `chain_en` low, `q` holds across rising edges.
- R6: Counting from the all-ones value gives 0 on the next edge.
- R7: `term_out` is high exactly when `chain_en` is high and `q` is all ones. `cnt_en` does not affect it.
- R8: Three stages chained through `term_out` into the next `chain_en` count as one 12-bit synchronous counter, rolling over from 4095 to 0.
- R9: A falling clock edge leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge only |
| zero_n | input | 1 | Asynchronous active-low clear of the count |
| ld_n | input | 1 | Synchronous active-low parallel load |
| cnt_en | input | 1 | Count enable, not seen by the terminal output |
| chain_en | input | 1 | Count enable that also gates the terminal output |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| term_out | output | 1 | High at all-ones count while chain_en is high |

## Verification
Load and count can both be requested in the same cycle. The bench holds both enables high while it loads each of the sixteen values, and a loaded value that came out one higher would show the wrong priority. The asynchronous clear is also dropped halfway through a cycle while a load is pending, and the count is checked before the next edge and again after it. In the cascade, one stage rolls over in the same edge where the stage above advances. This is judged against an arithmetic 12-bit model on every cycle, across two complete rollovers.

// File: rtl/sync_count_pkg.sv
package sync_count_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } act_e;
endpackage

// File: rtl/sync_count_ctrl.sv
module sync_count_ctrl
   import sync_count_pkg::*;
(
   input  logic ld_n,
   input  logic cnt_en,
   input  logic chain_en,
   output act_e act
);
   // load outranks counting; clear is handled asynchronously at the register
   always_comb begin
      if (!ld_n)                    act = ACT_LOAD;
      else if (cnt_en && chain_en)  act = ACT_STEP;
      else                          act = ACT_HOLD;
   end
endmodule

// File: rtl/sync_count_next.sv
module sync_count_next
   import sync_count_pkg::*;
#(
   parameter int WIDTH        = 4,
   parameter bit TOGGLE_CHAIN = 1'b1
)(
   input  act_e             act,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);
   logic [WIDTH-1:0] inc;

   generate
      if (TOGGLE_CHAIN) begin : g_toggle
         // bit i flips when every lower bit is one
         logic [WIDTH:0] all_low;
         assign all_low[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign all_low[i+1] = all_low[i] & cur[i];
            assign inc[i]       = cur[i] ^ all_low[i];
         end
      end else begin : g_adder
         assign inc = cur + WIDTH'(1);
      end
   endgenerate

   always_comb begin
      case (act)
         ACT_LOAD: nxt = din;
         ACT_STEP: nxt = inc;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/sync_count_term.sv
module sync_count_term #(
   parameter int WIDTH = 4
)(
   input  logic [WIDTH-1:0] cur,
   input  logic             chain_en,
   output logic             term_out
);
   assign term_out = chain_en & (&cur);
endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
   import sync_count_pkg::*;
#(
   parameter int WIDTH        = 4,
   parameter bit TOGGLE_CHAIN = 1'b1
)(
   input  logic             clk,
   input  logic             zero_n,
   input  logic             ld_n,
   input  logic             cnt_en,
   input  logic             chain_en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             term_out
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sync_count_stage: WIDTH must be at least 1");
      end
   endgenerate

   act_e             act;
   logic [WIDTH-1:0] nxt;

   sync_count_ctrl u_ctrl (
      .ld_n     (ld_n),
      .cnt_en   (cnt_en),
      .chain_en (chain_en),
      .act      (act)
   );

   sync_count_next #(.WIDTH(WIDTH), .TOGGLE_CHAIN(TOGGLE_CHAIN)) u_next (
      .act (act),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   sync_count_term #(.WIDTH(WIDTH)) u_term (
      .cur      (q),
      .chain_en (chain_en),
      .term_out (term_out)
   );

   always_ff @(posedge clk or negedge zero_n) begin
      if (!zero_n) q <= '0;
      else         q <= nxt;
   end

   assert_clear_zero_R1: assert property (@(posedge clk) !zero_n |-> (q == '0))
      else $error("R1: count not zero during clear");

   assert_load_takes_R2: assert property (@(posedge clk) disable iff (!zero_n)
      !ld_n |=> (q == $past(din)))
      else $error("R2: load value not taken");

   assert_step_one_R3: assert property (@(posedge clk) disable iff (!zero_n)
      (ld_n && cnt_en && chain_en) |=> (q == WIDTH'($past(q) + 1'b1)))
      else $error("R3: count did not advance by one");

   assert_hold_cnt_R4: assert property (@(posedge clk) disable iff (!zero_n)
      (ld_n && !cnt_en) |=> $stable(q))
      else $error("R4: count moved with cnt_en low");

   assert_hold_chain_R5: assert property (@(posedge clk) disable iff (!zero_n)
      (ld_n && !chain_en) |=> $stable(q))
      else $error("R5: count moved with chain_en low");

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!zero_n)
      (ld_n && cnt_en && chain_en && q == ALL_ONES) |=> (q == '0))
      else $error("R6: no wrap to zero");

   assert_term_hi_R7: assert property (@(posedge clk)
      (chain_en && q == ALL_ONES) |-> term_out)
      else $error("R7: terminal output missing");

   assert_term_lo_R7: assert property (@(posedge clk)
      (!chain_en || q != ALL_ONES) |-> !term_out)
      else $error("R7: terminal output spurious");
endmodule

// File: tb/sync_count_stage_test.sv
module sync_count_stage_test;
   logic       clk = 1'b0;
   logic       zero_n = 1'b0, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
   logic [3:0] din = 4'd0;
   logic [3:0] q;
   logic       term_out;

   // cascade signals
   logic [11:0] cdin = 12'd0;
   logic [3:0]  cq0, cq1, cq2;
   logic        t0, t1, t2;

   int total = 0;
   int bad   = 0;
   int m     = 0;   // single stage model
   int cm    = 0;   // cascade model

   always #10 clk = ~clk;

   sync_count_stage uut (
      .clk(clk), .zero_n(zero_n), .ld_n(ld_n), .cnt_en(cnt_en),
      .chain_en(chain_en), .din(din), .q(q), .term_out(term_out));

   sync_count_stage #(.TOGGLE_CHAIN(1'b0)) c0 (
      .clk(clk), .zero_n(zero_n), .ld_n(ld_n), .cnt_en(cnt_en),
      .chain_en(chain_en), .din(cdin[3:0]), .q(cq0), .term_out(t0));
   sync_count_stage c1 (
      .clk(clk), .zero_n(zero_n), .ld_n(ld_n), .cnt_en(cnt_en),
      .chain_en(t0), .din(cdin[7:4]), .q(cq1), .term_out(t1));
   sync_count_stage c2 (
      .clk(clk), .zero_n(zero_n), .ld_n(ld_n), .cnt_en(cnt_en),
      .chain_en(t1), .din(cdin[11:8]), .q(cq2), .term_out(t2));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one rising edge: update models from the inputs held across it, then compare
   task automatic tick(input string tag);
      @(posedge clk);
      if (!zero_n)                 begin m = 0; cm = 0; end
      else if (!ld_n)              begin m = din; cm = cdin; end
      else if (cnt_en && chain_en) begin m = (m + 1) % 16; cm = (cm + 1) % 4096; end
      #2;
      check(q == m[3:0], tag, q, m);
      check(term_out == (chain_en && m == 15), {tag, " R7 term"}, term_out, chain_en && m == 15);
      check({cq2, cq1, cq0} == cm[11:0], {tag, " R8 cascade"}, {cq2, cq1, cq0}, cm);
   endtask

   initial begin
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state
      tick("R1 reset");
      tick("R1 reset");
      @(negedge clk);
      zero_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;

      // R3 counting, R6 wrap, R7 terminal
      for (int i = 0; i < 20; i++) tick("R3 R6 count");

      // R9: falling edge changes nothing
      @(negedge clk); #2;
      check(q == m[3:0], "R9 falling edge", q, m);

      // park at 15 by load, then R4 hold with cnt_en low: R7 term stays high
      ld_n = 1'b0; din = 4'hF; tick("R2 load 15");
      ld_n = 1'b1; cnt_en = 1'b0;
      for (int i = 0; i < 4; i++) tick("R4 hold cnt_en low");
      check(term_out == 1'b1, "R7 term ignores cnt_en", term_out, 1);
      // R5 hold with chain_en low, term low
      cnt_en = 1'b1; chain_en = 1'b0;
      for (int i = 0; i < 4; i++) tick("R5 hold chain_en low");
      check(term_out == 1'b0, "R7 term gated by chain_en", term_out, 0);
      cnt_en = 1'b0;
      tick("R5 both low");

      // R2 load every value with both enables high (load wins)
      cnt_en = 1'b1; chain_en = 1'b1;
      for (int v = 0; v < 16; v++) begin
         ld_n = 1'b0; din = v[3:0];
         tick("R2 load priority");
         ld_n = 1'b1;
         tick("R3 step after load");
      end

      // R1 clear mid-cycle with load pending
      for (int i = 0; i < 3; i++) tick("R3 pre-clear");
      ld_n = 1'b0; din = 4'hA;
      #5 zero_n = 1'b0;
      #2;
      check(q == 4'd0, "R1 async clear no edge", q, 0);
      check({cq2, cq1, cq0} == 12'd0, "R1 cascade clear", {cq2, cq1, cq0}, 0);
      m = 0; cm = 0;
      tick("R1 held clear");
      #3 zero_n = 1'b1; ld_n = 1'b1;
      tick("R3 after clear");

      // R8 cascade: load near top, run through two rollovers
      ld_n = 1'b0; cdin = 12'hFF0; din = 4'h3;
      tick("R8 cascade load");
      ld_n = 1'b1;
      for (int i = 0; i < 4200; i++) tick("R8 cascade count");
      chain_en = 1'b0;
      for (int i = 0; i < 3; i++) tick("R8 cascade hold");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule